// File: doc/BRIEF.md
# Spare-Column Row Shift Repair Network

This block sits between a grid of processing cells and the logic that feeds them. Each row offers `LANES` logical data lanes to the surrounding logic but owns `LANES+1` physical cells. The last physical cell in every row is a spare. A per-row fault table is loaded through a small write port: a row number, a column number and a valid flag. From that table the block scatters the logical lanes of every row onto working physical cells and gathers the cell results back into logical order.

When a row has a recorded bad column, every lane from that column rightwards moves one physical cell to the right, into the spare. Lanes to its left stay where they are. Each row is handled on its own, so every row can lose one cell at the same time. A second fault recorded in a row cannot be repaired. It raises a sticky per-row flag. That row keeps the mapping set by its first fault. The steering is purely combinational from the registered table, so a table write changes the data paths from the next clock edge.

Top module: `spare_shift_repair`

## Requirements
- R1: A synchronous active-high reset empties the fault table and clears every unrepairable flag, so every row returns to the straight mapping.
- R2: In a row with no recorded fault, physical cell p (p < LANES) is sent logical lane p, and the spare cell (index LANES) is sent all zeros.
- R3: In a row whose recorded fault column c is below LANES, physical cell p is sent lane p for p < c, all zeros for p = c, and lane p-1 for p > c.
- R4: Logical output j of a row is taken from physical result j when j is below that row's effective fault column, and from physical result j+1 otherwise. The effective column is LANES when there is no fault.
- R5: Recording column LANES, the spare itself, as faulty leaves the row on the straight mapping of R2.
- R6: A write with the valid flag low removes the row's recorded fault whatever the column input holds. The row then uses the straight mapping, and its unrepairable flag keeps its value.
- R7: A valid write to a row that already has a recorded fault sets that row's unrepairable flag and leaves the first recorded column in force.
- R8: Each row's mapping depends only on its own table entry; writes to one row do not change any other row's steering.
- R9: A table write takes effect at the clock edge on which it is sampled. Before that edge the old mapping still applies, and from that edge on the new mapping applies.
- R10: A valid write whose column is greater than LANES is ignored. It changes neither the entry nor the flag.
- R11: An unrepairable flag, once set, stays set through later writes, including clears; only reset lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr_en | input | 1 | Fault-table write strobe |
| map_wr_row | input | RW | Row addressed by the write |
| map_wr_col | input | CW | Faulty column, 0 to LANES |
| map_wr_valid | input | 1 | 1 records a fault, 0 clears the row |
| log_in | input | ROWS*LANES*DW | Logical lane data, row-major, lane j of row r at (r*LANES+j)*DW |
| phys_tx | output | ROWS*(LANES+1)*DW | Data sent to the physical cells, cell p of row r at (r*(LANES+1)+p)*DW |
| phys_rx | input | ROWS*(LANES+1)*DW | Results returned by the physical cells, same layout as phys_tx |
| log_out | output | ROWS*LANES*DW | Gathered logical results, same layout as log_in |
| row_unrepairable | output | ROWS | Sticky per-row double-fault flag |

## Verification
A corrupted table entry shows up at once on `phys_tx`. A lane lands one cell off, or a zeroed slot appears in the wrong place, or the spare carries data when it should be idle. Because the bench's cells add a distinct per-cell offset, a gather that reads the wrong result shows on `log_out` in the same cycle. An off-by-one in the write timing shows as a mapping that changes before the edge or one cycle late. A lost or spurious flag shows on `row_unrepairable` right after the write that should, or should not, have raised it.

// File: rtl/rowfix_pkg.sv
package rowfix_pkg;
    localparam int ROWS  = 4;
    localparam int LANES = 4;
    localparam int DW    = 8;

    localparam int CW    = $clog2(LANES + 1);
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CELLS = LANES + 1;
    localparam int LBITS = ROWS * LANES * DW;
    localparam int PBITS = ROWS * CELLS * DW;

    typedef struct packed {
        logic          valid;
        logic [CW-1:0] col;
    } fault_ent_t;

    // Column from which lanes are pushed right; LANES means no shift.
    function automatic logic [CW-1:0] shift_point(fault_ent_t e);
        if (e.valid && (e.col < CW'(LANES)))
            return e.col;
        return CW'(LANES);
    endfunction
endpackage

// File: rtl/fault_map_store.sv
module fault_map_store
    import rowfix_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [RW-1:0]            wr_row,
    input  logic [CW-1:0]            wr_col,
    input  logic                     wr_valid,
    output fault_ent_t [ROWS-1:0]    map_q,
    output logic [ROWS-1:0]          unrep_q
);
    logic col_ok;
    assign col_ok = (wr_col <= CW'(LANES));

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q   <= '0;
            unrep_q <= '0;
        end else if (wr_en) begin
            if (!wr_valid) begin
                map_q[wr_row].valid <= 1'b0;
            end else if (col_ok) begin
                if (map_q[wr_row].valid) begin
                    unrep_q[wr_row] <= 1'b1;
                end else begin
                    map_q[wr_row].valid <= 1'b1;
                    map_q[wr_row].col   <= wr_col;
                end
            end
        end
    end
endmodule

// File: rtl/row_scatter.sv
module row_scatter
    import rowfix_pkg::*;
(
    input  logic [CW-1:0]         cut,
    input  logic [LANES*DW-1:0]   lanes,
    output logic [CELLS*DW-1:0]   cells
);
    for (genvar p = 0; p < CELLS; p++) begin : g_cell
        if (p == 0) begin : g_first
            assign cells[0 +: DW] = (cut == '0) ? '0 : lanes[0 +: DW];
        end else if (p == LANES) begin : g_spare
            assign cells[p*DW +: DW] = (cut == CW'(p)) ? '0 : lanes[(p-1)*DW +: DW];
        end else begin : g_mid
            assign cells[p*DW +: DW] = (CW'(p) < cut)  ? lanes[p*DW +: DW] :
                                       (CW'(p) == cut) ? '0 :
                                                         lanes[(p-1)*DW +: DW];
        end
    end
endmodule

// File: rtl/row_gather.sv
module row_gather
    import rowfix_pkg::*;
(
    input  logic [CW-1:0]         cut,
    input  logic [CELLS*DW-1:0]   results,
    output logic [LANES*DW-1:0]   lanes
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lanes[j*DW +: DW] = (CW'(j) < cut) ? results[j*DW +: DW]
                                                  : results[(j+1)*DW +: DW];
    end
endmodule

// File: rtl/spare_shift_repair.sv
module spare_shift_repair
    import rowfix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 map_wr_en,
    input  logic [RW-1:0]        map_wr_row,
    input  logic [CW-1:0]        map_wr_col,
    input  logic                 map_wr_valid,
    input  logic [LBITS-1:0]     log_in,
    output logic [PBITS-1:0]     phys_tx,
    input  logic [PBITS-1:0]     phys_rx,
    output logic [LBITS-1:0]     log_out,
    output logic [ROWS-1:0]      row_unrepairable
);
    fault_ent_t [ROWS-1:0] fmap;

    fault_map_store i_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (map_wr_en),
        .wr_row  (map_wr_row),
        .wr_col  (map_wr_col),
        .wr_valid(map_wr_valid),
        .map_q   (fmap),
        .unrep_q (row_unrepairable)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [CW-1:0] cut;
        assign cut = shift_point(fmap[r]);

        row_scatter i_scatter (
            .cut  (cut),
            .lanes(log_in[r*LANES*DW +: LANES*DW]),
            .cells(phys_tx[r*CELLS*DW +: CELLS*DW])
        );

        row_gather i_gather (
            .cut    (cut),
            .results(phys_rx[r*CELLS*DW +: CELLS*DW]),
            .lanes  (log_out[r*LANES*DW +: LANES*DW])
        );
    end
endmodule

// File: rtl/spare_shift_repair_chk.sv
module spare_shift_repair_chk
    import rowfix_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  map_wr_en,
    input logic [RW-1:0]         map_wr_row,
    input logic [CW-1:0]         map_wr_col,
    input logic                  map_wr_valid,
    input fault_ent_t [ROWS-1:0] fmap,
    input logic [ROWS-1:0]       row_unrepairable,
    input logic [PBITS-1:0]      phys_tx
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (row_unrepairable == '0) && (fmap == '0));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // R2
        spare_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (!fmap[r].valid || fmap[r].col >= CW'(LANES))
            |-> (phys_tx[(r*CELLS+LANES)*DW +: DW] == '0));

        // R3
        bad_cell_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (fmap[r].valid && fmap[r].col < CW'(LANES))
            |-> (phys_tx[(r*CELLS+fmap[r].col)*DW +: DW] == '0));

        // R9
        write_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (map_wr_en && map_wr_valid && map_wr_row == RW'(r) &&
             !fmap[r].valid && map_wr_col <= CW'(LANES))
            |=> (fmap[r].valid && fmap[r].col == $past(map_wr_col)));

        // R6
        clear_lands_chk: assert property (@(posedge clk) disable iff (rst)
            (map_wr_en && !map_wr_valid && map_wr_row == RW'(r))
            |=> !fmap[r].valid);

        // R7
        second_fault_chk: assert property (@(posedge clk) disable iff (rst)
            (map_wr_en && map_wr_valid && map_wr_row == RW'(r) &&
             fmap[r].valid && map_wr_col <= CW'(LANES))
            |=> (row_unrepairable[r] && fmap[r] == $past(fmap[r])));

        // R11
        flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            row_unrepairable[r] |=> row_unrepairable[r]);
    end
endmodule

bind spare_shift_repair spare_shift_repair_chk i_chk (
    .clk             (clk),
    .rst             (rst),
    .map_wr_en       (map_wr_en),
    .map_wr_row      (map_wr_row),
    .map_wr_col      (map_wr_col),
    .map_wr_valid    (map_wr_valid),
    .fmap            (fmap),
    .row_unrepairable(row_unrepairable),
    .phys_tx         (phys_tx)
);

// File: tb/test_spare_shift_repair.sv
module test_spare_shift_repair;
    import rowfix_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             map_wr_en = 1'b0;
    logic [RW-1:0]    map_wr_row = '0;
    logic [CW-1:0]    map_wr_col = '0;
    logic             map_wr_valid = 1'b0;
    logic [LBITS-1:0] log_in = '0;
    logic [PBITS-1:0] phys_tx;
    logic [PBITS-1:0] phys_rx;
    logic [LBITS-1:0] log_out;
    logic [ROWS-1:0]  row_unrepairable;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Bench model of the fault table, from the requirements.
    bit       m_valid [ROWS];
    int       m_col   [ROWS];
    bit       m_unrep [ROWS];

    always #(CLK_PERIOD/2) clk = ~clk;

    spare_shift_repair i_spare_shift_repair (
        .clk             (clk),
        .rst             (rst),
        .map_wr_en       (map_wr_en),
        .map_wr_row      (map_wr_row),
        .map_wr_col      (map_wr_col),
        .map_wr_valid    (map_wr_valid),
        .log_in          (log_in),
        .phys_tx         (phys_tx),
        .phys_rx         (phys_rx),
        .log_out         (log_out),
        .row_unrepairable(row_unrepairable)
    );

    function automatic logic [DW-1:0] cell_key(int r, int p);
        return DW'(r * 16 + p + 1);
    endfunction

    // Each physical cell adds its own key to what it receives.
    always_comb begin
        for (int r = 0; r < ROWS; r++)
            for (int p = 0; p < CELLS; p++)
                phys_rx[(r*CELLS+p)*DW +: DW] = phys_tx[(r*CELLS+p)*DW +: DW] + cell_key(r, p);
    end

    function automatic int model_cut(int r);
        if (m_valid[r] && m_col[r] < LANES) return m_col[r];
        return LANES;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < ROWS; r++) begin
            m_valid[r] = 1'b0; m_col[r] = 0; m_unrep[r] = 1'b0;
        end
    endtask

    task automatic model_write(int r, int c, bit v);
        if (!v) m_valid[r] = 1'b0;
        else if (c <= LANES) begin
            if (m_valid[r]) m_unrep[r] = 1'b1;
            else begin m_valid[r] = 1'b1; m_col[r] = c; end
        end
    endtask

    task automatic fill_lanes(int seed);
        for (int r = 0; r < ROWS; r++)
            for (int j = 0; j < LANES; j++)
                log_in[(r*LANES+j)*DW +: DW] = DW'(seed * 37 + r * 11 + j * 3 + 5);
    endtask

    task automatic check_all(string tag);
        for (int r = 0; r < ROWS; r++) begin
            logic [CELLS*DW-1:0] exp_tx;
            logic [LANES*DW-1:0] exp_out;
            int cut;
            cut = model_cut(r);
            for (int p = 0; p < CELLS; p++) begin
                if (p < cut)       exp_tx[p*DW +: DW] = log_in[(r*LANES+p)*DW +: DW];
                else if (p == cut) exp_tx[p*DW +: DW] = '0;
                else               exp_tx[p*DW +: DW] = log_in[(r*LANES+p-1)*DW +: DW];
            end
            for (int j = 0; j < LANES; j++) begin
                int src;
                src = (j < cut) ? j : j + 1;
                exp_out[j*DW +: DW] = log_in[(r*LANES+j)*DW +: DW] + cell_key(r, src);
            end
            checks++;
            if (phys_tx[r*CELLS*DW +: CELLS*DW] !== exp_tx) begin
                errors++;
                $display("FAIL %s row %0d phys_tx got %h exp %h", tag, r,
                         phys_tx[r*CELLS*DW +: CELLS*DW], exp_tx);
            end
            checks++;
            if (log_out[r*LANES*DW +: LANES*DW] !== exp_out) begin
                errors++;
                $display("FAIL %s row %0d log_out got %h exp %h", tag, r,
                         log_out[r*LANES*DW +: LANES*DW], exp_out);
            end
        end
        begin
            logic [ROWS-1:0] exp_flags;
            for (int r = 0; r < ROWS; r++) exp_flags[r] = m_unrep[r];
            checks++;
            if (row_unrepairable !== exp_flags) begin
                errors++;
                $display("FAIL %s row_unrepairable got %b exp %b", tag,
                         row_unrepairable, exp_flags);
            end
        end
    endtask

    // Drive at a falling edge, sampled at the next rising edge.
    task automatic do_write(int r, int c, bit v);
        @(negedge clk);
        map_wr_en = 1'b1; map_wr_row = RW'(r); map_wr_col = CW'(c); map_wr_valid = v;
        @(posedge clk);
        model_write(r, c, v);
        @(negedge clk);
        map_wr_en = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        model_reset();
        fill_lanes(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 check_all("R1 after reset");

        // R2 R3 R4 R5 R8: every fault column and none, rows staggered.
        for (int f = 0; f < LANES + 2; f++) begin
            for (int r = 0; r < ROWS; r++) begin
                int c;
                c = (f + r) % (LANES + 2);
                do_write(r, 0, 1'b0);
                if (c <= LANES) do_write(r, c, 1'b1);
            end
            for (int s = 0; s < 3; s++) begin
                fill_lanes(f * 7 + s);
                #1 check_all("R2/R3/R4/R5/R8 sweep");
            end
        end

        // R9: old mapping until the edge, new mapping from it.
        do_write(0, 0, 1'b0);
        fill_lanes(40);
        @(negedge clk);
        map_wr_en = 1'b1; map_wr_row = '0; map_wr_col = CW'(1); map_wr_valid = 1'b1;
        #1 check_all("R9 before edge");
        @(posedge clk);
        model_write(0, 1, 1'b1);
        @(negedge clk);
        map_wr_en = 1'b0;
        #1 check_all("R9 after edge");

        // R7: second fault flags the row, first column stays.
        do_write(2, 0, 1'b0);
        do_write(2, 1, 1'b1);
        do_write(2, 3, 1'b1);
        #1 check_all("R7 second fault");

        // R11 / R6: clear keeps flag; new fault keeps flag.
        do_write(2, 7, 1'b0);
        #1 check_all("R6/R11 clear keeps flag");
        do_write(2, 0, 1'b1);
        fill_lanes(55);
        #1 check_all("R11 flag after new fault");

        // R10: out-of-range column ignored, on an empty and a faulted row.
        do_write(1, 0, 1'b0);
        do_write(1, LANES + 2, 1'b1);
        #1 check_all("R10 ignored on empty row");
        do_write(3, 0, 1'b0);
        do_write(3, 2, 1'b1);
        do_write(3, LANES + 1, 1'b1);
        #1 check_all("R10 ignored on faulted row");

        // R1: reset mid-run.
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        fill_lanes(77);
        #1 check_all("R1 mid-run reset");

        finished = 1'b1;
        report();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            report();
        end
    end
endmodule